// File: doc/BRIEF.md
# USB SETUP Packet Capture Lock

This block sits between the endpoint protocol engine of a USB device and its firmware. It collects the eight bytes of a control-transfer SETUP payload into four 16-bit words. Software reads these words over a small register bus. Standard, class and vendor requests are all handled the same way: the block decodes nothing and hands the raw payload to software.

Once a payload is complete, the block raises a pending flag. It also tells the protocol engine to NACK every IN or OUT data transaction until software writes a ready bit. The four words are write-protected while any of them is still unread. A SETUP packet that starts during that time is discarded, and a sticky overrun flag records the loss.

The register bus uses addresses 0 to 3 for the payload words and the next address for a combined status and control register. Read data appears on `reg_rdata_o` one cycle after the read strobe.

Top module: `setup_capture`

## Requirements
- R1: After reset, nack_o is low, the status register (address 4) reads zero, and all four payload words read zero.
- R2: Payload byte k of an accepted packet is stored in word k/2. Even k goes in bits 7:0 and odd k in bits 15:8. A read strobe on address 0 to 3 returns that word on reg_rdata_o in the next cycle.
- R3: Once eight bytes have been stored, the words are locked until each of addresses 0 to 3 has been read at least once. A packet whose start pulse arrives while locked is dropped entirely, and the stored words do not change.
- R4: nack_o rises in the cycle after the eighth byte is stored. It stays high until software writes the ready bit.
- R5: A write to address 4 with bit 0 set clears the pending flag (status bit 5) and nack_o from the next cycle on. It does not change the lock or the read mask.
- R6: A dropped packet sets the overrun flag (status bit 6). The flag stays set until a write to address 4 with bit 1 set.
- R7: Status bits 3:0 show which words have been read, with bit i for address i. Status bit 4 is the lock: high when a capture exists and not all four bits are set. The mask clears when a new capture completes.
- R8: A start pulse before the eighth byte restarts assembly at byte 0, and pending stays low until eight bytes have arrived. Bytes that follow the eighth without a new start pulse are ignored.
- R9: Reading the status register has no side effect. Reading a word address more than once still sets only its own mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_start_i | input | 1 | Pulse marking the start of a SETUP data packet |
| byte_vld_i | input | 1 | Payload byte valid |
| byte_i | input | 8 | Payload byte |
| nack_o | output | 1 | Request to NACK IN/OUT data transactions |
| reg_addr_i | input | 3 | Register address |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid one cycle after the strobe |

## Verification
A wrong read mask shows up in status bits 3:0 on the next status read. It also changes whether the following SETUP packet is kept or dropped, which is visible both in the overrun bit and in the word contents one read later. A pending flag that is set or cleared wrongly appears on nack_o in the very next cycle. A faulty byte counter packs bytes into the wrong lanes, or raises pending too early or too late, and the first word read after the packet exposes it.

// File: rtl/setup_cap_pkg.sv
package setup_cap_pkg;
  localparam int unsigned CTRL_READY_BIT   = 0;
  localparam int unsigned CTRL_CLR_OVR_BIT = 1;

  // status layout: [n-1:0] read mask, then lock, pending, overrun
  function automatic int unsigned st_lock_bit(input int unsigned n);
    return n;
  endfunction
  function automatic int unsigned st_pend_bit(input int unsigned n);
    return n + 1;
  endfunction
  function automatic int unsigned st_ovr_bit(input int unsigned n);
    return n + 2;
  endfunction
endpackage

// File: rtl/setup_byte_asm.sv
module setup_byte_asm #(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned BYTE_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        accept_i,
  input  logic                        vld_i,
  input  logic [BYTE_W-1:0]           data_i,
  output logic [NUM_WORDS*WORD_W-1:0] words_o,
  output logic                        done_o
);
  localparam int unsigned BPW   = WORD_W / BYTE_W;
  localparam int unsigned NB    = NUM_WORDS * BPW;
  localparam int unsigned IDX_W = $clog2(NB);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic             wr_en;

  assign wr_en  = active_q && vld_i && !start_i;
  assign done_o = wr_en && (idx_q == IDX_W'(NB - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= accept_i;
      idx_q    <= '0;
    end else if (wr_en) begin
      idx_q <= idx_q + 1'b1;
      if (done_o) active_q <= 1'b0;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar b = 0; b < BPW; b++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          words_o[w*WORD_W + b*BYTE_W +: BYTE_W] <= '0;
        else if (wr_en && idx_q == IDX_W'(w*BPW + b))
          words_o[w*WORD_W + b*BYTE_W +: BYTE_W] <= data_i;
      end
    end
  end

  assert_drop_whole_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !accept_i) |=> !active_q);
  assert_last_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!active_q && idx_q == '0));
endmodule

// File: rtl/setup_read_track.sv
module setup_read_track #(
  parameter int unsigned NUM_WORDS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 done_i,
  input  logic [NUM_WORDS-1:0] rd_hit_i,
  output logic [NUM_WORDS-1:0] mask_o,
  output logic                 locked_o
);
  logic captured_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      captured_q <= 1'b0;
      mask_o     <= '0;
    end else if (done_i) begin
      captured_q <= 1'b1;
      mask_o     <= '0;
    end else begin
      mask_o <= mask_o | rd_hit_i;
    end
  end

  assign locked_o = captured_q && !(&mask_o);

  assert_mask_grows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> ((mask_o & $past(mask_o)) == $past(mask_o)));
  assert_capture_locks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (locked_o && mask_o == '0));
  assert_single_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($onehot0(rd_hit_i) && !done_i) |=> ($countones(mask_o ^ $past(mask_o)) <= 1));
endmodule

// File: rtl/setup_capture.sv
module setup_capture
  import setup_cap_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned ADDR_W    = $clog2(NUM_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              setup_start_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              nack_o,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o
);
  localparam int unsigned CTRL_ADDR = NUM_WORDS;
  localparam int unsigned LOCK_BIT  = st_lock_bit(NUM_WORDS);
  localparam int unsigned PEND_BIT  = st_pend_bit(NUM_WORDS);
  localparam int unsigned OVR_BIT   = st_ovr_bit(NUM_WORDS);

  logic [NUM_WORDS*WORD_W-1:0] words;
  logic [NUM_WORDS-1:0]        rd_hit, mask;
  logic                        locked, done, drop;
  logic                        pend_q, ovr_q;
  logic                        ctrl_wr;
  logic [WORD_W-1:0]           status, rd_mux;

  assign drop    = setup_start_i && locked;
  assign ctrl_wr = reg_wr_i && reg_addr_i == ADDR_W'(CTRL_ADDR);

  setup_byte_asm #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_asm (
    .clk_i, .rst_ni,
    .start_i (setup_start_i),
    .accept_i(!locked),
    .vld_i   (byte_vld_i),
    .data_i  (byte_i),
    .words_o (words),
    .done_o  (done)
  );

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_hit
    assign rd_hit[i] = reg_rd_i && reg_addr_i == ADDR_W'(i);
  end

  setup_read_track #(.NUM_WORDS(NUM_WORDS)) u_trk (
    .clk_i, .rst_ni,
    .done_i  (done),
    .rd_hit_i(rd_hit),
    .mask_o  (mask),
    .locked_o(locked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (done)                                      pend_q <= 1'b1;
      else if (ctrl_wr && reg_wdata_i[CTRL_READY_BIT]) pend_q <= 1'b0;
      if (drop)                                       ovr_q <= 1'b1;
      else if (ctrl_wr && reg_wdata_i[CTRL_CLR_OVR_BIT]) ovr_q <= 1'b0;
    end
  end

  assign nack_o = pend_q;

  always_comb begin
    status                     = '0;
    status[NUM_WORDS-1:0]      = mask;
    status[LOCK_BIT]           = locked;
    status[PEND_BIT]           = pend_q;
    status[OVR_BIT]            = ovr_q;
    rd_mux                     = '0;
    if (reg_addr_i == ADDR_W'(CTRL_ADDR)) rd_mux = status;
    for (int i = 0; i < NUM_WORDS; i++)
      if (reg_addr_i == ADDR_W'(i)) rd_mux = words[i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end

  assert_words_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(words));
  assert_nack_after_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> nack_o);
  assert_ready_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[CTRL_READY_BIT] && !done) |=> !nack_o);
  assert_ovr_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> ovr_q);
  assert_ovr_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !(ctrl_wr && reg_wdata_i[CTRL_CLR_OVR_BIT])) |=> ovr_q);
  assert_nack_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nack_o) |-> $past(done));
endmodule

// File: tb/tb_setup_capture.sv
module tb_setup_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        setup_start_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        nack_o;
  logic [2:0]  reg_addr_i = '0;
  logic        reg_rd_i = 1'b0, reg_wr_i = 1'b0;
  logic [15:0] reg_wdata_i = '0, reg_rdata_o;

  int checks = 0, errors = 0;
  logic [15:0] ew [4];
  logic [3:0]  emask;
  logic        ecap, epend, eovr;

  always #5 clk_i = ~clk_i;

  setup_capture dut (.*);

  function automatic logic elock();
    return ecap && (emask != 4'hF);
  endfunction
  function automatic logic [15:0] estatus();
    return {9'd0, eovr, epend, elock(), emask};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr_i = a; reg_rd_i = 1'b1;
    @(negedge clk_i);
    reg_rd_i = 1'b0; d = reg_rdata_o;
    if (a < 4) emask[a] = 1'b1;
  endtask

  task automatic chk_rd(input string req, input logic [2:0] a);
    logic [15:0] e, d;
    e = (a < 4) ? ew[a] : (a == 4) ? estatus() : 16'h0;
    rd(a, d);
    chk(req, d, e);
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    reg_addr_i = 3'd4; reg_wdata_i = v; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    if (v[0]) epend = 1'b0;
    if (v[1]) eovr = 1'b0;
    chk("R5 nack", {15'd0, nack_o}, {15'd0, epend});
  endtask

  task automatic send(input int n);
    logic acc;
    acc = !elock();
    setup_start_i = 1'b1;
    @(negedge clk_i);
    setup_start_i = 1'b0;
    if (!acc) eovr = 1'b1;
    for (int i = 0; i < n; i++) begin
      byte_i = 8'($urandom); byte_vld_i = 1'b1;
      @(negedge clk_i);
      if (acc && i < 8) begin
        ew[i/2][(i%2)*8 +: 8] = byte_i;
        if (i == 7) begin ecap = 1'b1; emask = '0; epend = 1'b1; end
      end
    end
    byte_vld_i = 1'b0;
    chk("R4 nack", {15'd0, nack_o}, {15'd0, epend});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5eed_c0de));
    foreach (ew[i]) ew[i] = '0;
    emask = '0; ecap = 0; epend = 0; eovr = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 nack", {15'd0, nack_o}, 16'h0);
    chk_rd("R1 status", 3'd4);
    for (int a = 0; a < 4; a++) chk_rd("R1 word", 3'(a));
    emask = '0; ecap = 0;

    // R2 packing, R4 nack
    send(8);
    for (int a = 0; a < 4; a++) chk_rd("R2 word", 3'(a));
    chk_rd("R7 status all read", 3'd4);
    // R3 lock: read three, new packet dropped
    send(8);
    chk_rd("R9 status no side effect", 3'd4);
    chk_rd("R9 repeat", 3'd1); chk_rd("R9 repeat", 3'd1);
    chk_rd("R3 word", 3'd0); chk_rd("R3 word", 3'd2);
    chk_rd("R7 mask", 3'd4);
    send(8);
    chk_rd("R6 overrun", 3'd4);
    chk_rd("R3 unchanged", 3'd3);
    wr_ctrl(16'h0001);
    chk_rd("R5 lock kept", 3'd4);
    wr_ctrl(16'h0002);
    chk_rd("R6 cleared", 3'd4);
    // R8 truncated then restart, trailing bytes ignored
    send(5);
    chk_rd("R8 no pending", 3'd4);
    send(11);
    for (int a = 0; a < 4; a++) chk_rd("R8 word", 3'(a));
    chk_rd("R8 status", 3'd4);

    for (int k = 0; k < 400; k++) begin
      case ($urandom % 6)
        0: send(($urandom % 4 == 0) ? int'($urandom % 10) : 8);
        1, 2: chk_rd("R2 rnd", 3'($urandom % 4));
        3: chk_rd("R7 rnd status", 3'd4);
        4: wr_ctrl(16'($urandom % 4));
        default: chk("R4 rnd nack", {15'd0, nack_o}, {15'd0, epend});
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule